// File: doc/BRIEF.md
# Address and Data Match Breakpoint Trigger Bank

This block holds a small bank of programmable breakpoint comparators for a processor core. Every cycle in which the core presents an access (an instruction fetch, a load or a store), each trigger compares either the byte addresses the access touches or the value it carries against its own programmed reference. The comparison uses one of several match modes: exact, naturally aligned power-of-two region, unsigned bounds, half-word masked compare, or the inverse of any of these.

A trigger only reports a match when the access kind, the access size and the current privilege level are all enabled in its configuration. It also takes into account whether the core marked the evaluation of the access as uncertain. Triggers can be linked into a chain so that the whole group fires only when every member matched the same access. Each firing sets a sticky two-bit hit code. Results are registered and appear one clock after the access is presented.

Top module: `trig_bank`

## Requirements
- R1: Mode 0 matches when a compare value equals the reference; mode 8 matches exactly when mode 0 would not.
- R2: Mode 1 (region) ignores every reference bit from bit 0 up to and including the lowest zero bit, but never ignores bits at or above NAPOT_MAX (default 12); mode 9 is its inverse.
- R3: Mode 2 matches a compare value unsigned greater than or equal to the reference; mode 3 matches one unsigned less than it.
- R4: With H = XLEN/2, mode 4 matches when (low half of value AND high half of reference) equals the low half of reference; mode 5 does the same with the high half of the value; modes 12 and 13 invert 4 and 5.
- R5: With select=0 the compare values are every byte address of the access (address, address+1, ... up to its size); a match on any one of them counts, and inverse modes invert that combined result.
- R6: With select=1 the single compare value is the access data, zero-extended above the access size.
- R7: Size codes are 1=1, 2=2, 3=4, 4=6, 5=8, 6=16 bytes; a nonzero trigger size code matches only accesses of that code, and code 4 matches only executes; trigger code 0 accepts any size.
- R8: Kind codes are 0 execute, 1 load, 2 store, enabled by kind-enable bits [0],[1],[2]; privilege codes 0 U, 1 S, 3 M, 4 VU, 5 VS are enabled by privilege-enable bits [0]..[4] in that order; other privilege codes never match.
- R9: An access flagged uncertain matches only when the trigger's uncertain enable is set, and firing on such an access sets that trigger's sticky uncertain flag.
- R10: A trigger with chain=1 passes permission to the next index only when it matched; a chain fires (all its members together) only when every member matched, a chain left open at the last index never fires, and permit_o is 1 for an unchained trigger.
- R11: On firing, hit code becomes 1 when timing=0 and 3 when timing=1; the code and uncertain flag are sticky until hit_clr_i, and a firing in the same cycle as a clear wins.
- R12: match_o, permit_o and fire_o report the access presented at the previous rising clock and are 0 after a cycle without an access; all outputs are 0 in reset.
- R13: Reserved mode codes (6, 7, 10, 11, 14, 15) never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_kind_i | input | 2 | Access kind code |
| acc_addr_i | input | XLEN | Lowest byte address of the access |
| acc_data_i | input | XLEN | Data loaded or stored, or instruction word |
| acc_size_i | input | 3 | Access size code |
| acc_priv_i | input | 3 | Privilege code of the access |
| acc_uncertain_i | input | 1 | Access evaluation is not exact |
| cfg_mode_i | input | NTRIG x 4 | Match mode per trigger |
| cfg_select_i | input | NTRIG | 0 compare addresses, 1 compare data |
| cfg_timing_i | input | NTRIG | Reported timing: 0 before, 1 after retirement |
| cfg_size_i | input | NTRIG x 3 | Required size code, 0 for any |
| cfg_chain_i | input | NTRIG | Link to the next trigger |
| cfg_kind_en_i | input | NTRIG x 3 | Execute, load, store enables |
| cfg_priv_en_i | input | NTRIG x 5 | U, S, M, VU, VS enables |
| cfg_uncert_en_i | input | NTRIG | Allow matching on uncertain accesses |
| cfg_value_i | input | NTRIG x XLEN | Reference value |
| hit_clr_i | input | NTRIG | Clear hit code and uncertain flag |
| match_o | output | NTRIG | Qualified match, before chaining |
| permit_o | output | NTRIG | Trigger lets the next index match |
| fire_o | output | NTRIG | Trigger fired |
| hit_o | output | NTRIG x 2 | Sticky hit code |
| uncert_o | output | NTRIG | Sticky fired-on-uncertain flag |

## Verification
The bench aims at the byte-lane edges of multi-byte accesses: a word that starts two bytes below the reference must hit, while one that ends just below must miss. A design comparing only the base address would miss the first case, and one that inverts lanes one by one would turn the inverse modes into near-constant matches. It checks the region mode at the lowest-zero boundary and at the NAPOT_MAX cap, data zero-extension, the execute-only 6-byte size, and a reserved privilege code. A flaw in any of these either opens or closes the matching window. Chains are driven with the head missing, the tail missing, and left open at the last index, so that a design firing on the tail alone or on an unterminated chain is exposed. The hit tests check the code values and the clear-against-fire priority.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC  = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2
  } acc_kind_e;

  localparam logic [2:0] PRV_U  = 3'd0;
  localparam logic [2:0] PRV_S  = 3'd1;
  localparam logic [2:0] PRV_M  = 3'd3;
  localparam logic [2:0] PRV_VU = 3'd4;
  localparam logic [2:0] PRV_VS = 3'd5;

  localparam logic [2:0] CMP_EQ    = 3'd0;
  localparam logic [2:0] CMP_NAPOT = 3'd1;
  localparam logic [2:0] CMP_GE    = 3'd2;
  localparam logic [2:0] CMP_LT    = 3'd3;
  localparam logic [2:0] CMP_MLO   = 3'd4;
  localparam logic [2:0] CMP_MHI   = 3'd5;

  localparam logic [2:0] SZ_48 = 3'd4;

  // bytes covered by an access size code; 0 marks an unusable code
  function automatic logic [4:0] size_bytes(input logic [2:0] code);
    logic [4:0] n;
    case (code)
      3'd1:    n = 5'd1;
      3'd2:    n = 5'd2;
      3'd3:    n = 5'd4;
      3'd4:    n = 5'd6;
      3'd5:    n = 5'd8;
      3'd6:    n = 5'd16;
      default: n = 5'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/trig_lane_cmp.sv
module trig_lane_cmp #(
  parameter int XLEN      = 32,
  parameter int NAPOT_MAX = 12
) (
  input  logic [XLEN-1:0] cmp_val_i,
  input  logic [XLEN-1:0] ref_val_i,
  input  logic [2:0]      base_i,
  output logic            hit_o
);
  import trig_pkg::*;

  localparam int H = XLEN / 2;
  localparam logic [XLEN-1:0] CAP_KEEP = {{(XLEN-NAPOT_MAX){1'b1}}, {NAPOT_MAX{1'b0}}};

  logic [XLEN-1:0] care;
  logic [H-1:0]    ref_lo, ref_hi, val_lo, val_hi;

  always_comb begin
    // bits through the lowest zero of the reference are don't-care, capped
    care   = ~(ref_val_i ^ (ref_val_i + XLEN'(1))) | CAP_KEEP;
    ref_lo = ref_val_i[H-1:0];
    ref_hi = ref_val_i[XLEN-1:H];
    val_lo = cmp_val_i[H-1:0];
    val_hi = cmp_val_i[XLEN-1:H];
    case (base_i)
      CMP_EQ:    hit_o = (cmp_val_i == ref_val_i);
      CMP_NAPOT: hit_o = ((cmp_val_i & care) == (ref_val_i & care));
      CMP_GE:    hit_o = (cmp_val_i >= ref_val_i);
      CMP_LT:    hit_o = (cmp_val_i < ref_val_i);
      CMP_MLO:   hit_o = ((val_lo & ref_hi) == ref_lo);
      CMP_MHI:   hit_o = ((val_hi & ref_hi) == ref_lo);
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/trig_unit.sv
module trig_unit #(
  parameter int XLEN      = 32,
  parameter int NAPOT_MAX = 12,
  parameter int LANES     = 16
) (
  input  logic [1:0]      acc_kind_i,
  input  logic [XLEN-1:0] acc_addr_i,
  input  logic [XLEN-1:0] acc_data_i,
  input  logic [2:0]      acc_size_i,
  input  logic [2:0]      acc_priv_i,
  input  logic            acc_uncertain_i,
  input  logic [3:0]      mode_i,
  input  logic            select_i,
  input  logic [2:0]      size_i,
  input  logic [2:0]      kind_en_i,
  input  logic [4:0]      priv_en_i,
  input  logic            uncert_en_i,
  input  logic [XLEN-1:0] value_i,
  output logic            match_o
);
  import trig_pkg::*;

  localparam int XBYTES = XLEN / 8;

  logic [2:0]       base;
  logic             invert, mode_ok;
  logic [4:0]       nbytes;
  logic [LANES-1:0] lane_hit, lane_act;
  logic [XLEN-1:0]  data_mask, data_cv;
  logic             data_hit, pos_hit, cmp_hit;
  logic             kind_ok, priv_ok, size_ok, unc_ok;

  assign base   = mode_i[2:0];
  assign invert = mode_i[3];
  assign nbytes = size_bytes(acc_size_i);

  // one comparator per byte the widest access can touch
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    trig_lane_cmp #(.XLEN(XLEN), .NAPOT_MAX(NAPOT_MAX)) lane_i (
      .cmp_val_i (acc_addr_i + XLEN'(g)),
      .ref_val_i (value_i),
      .base_i    (base),
      .hit_o     (lane_hit[g])
    );
  end

  trig_lane_cmp #(.XLEN(XLEN), .NAPOT_MAX(NAPOT_MAX)) data_cmp_i (
    .cmp_val_i (data_cv),
    .ref_val_i (value_i),
    .base_i    (base),
    .hit_o     (data_hit)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_act[k] = (k < int'(nbytes));
    end
    if (int'(nbytes) >= XBYTES) data_mask = '1;
    else                        data_mask = (XLEN'(1) << {nbytes, 3'b000}) - XLEN'(1);
    data_cv = acc_data_i & data_mask;
  end

  always_comb begin
    mode_ok = (base <= CMP_MHI) && !(invert && (base == CMP_GE || base == CMP_LT));
    pos_hit = select_i ? data_hit : |(lane_hit & lane_act);
    cmp_hit = invert ? !pos_hit : pos_hit;

    case (acc_kind_i)
      KIND_EXEC:  kind_ok = kind_en_i[0];
      KIND_LOAD:  kind_ok = kind_en_i[1];
      KIND_STORE: kind_ok = kind_en_i[2];
      default:    kind_ok = 1'b0;
    endcase

    case (acc_priv_i)
      PRV_U:   priv_ok = priv_en_i[0];
      PRV_S:   priv_ok = priv_en_i[1];
      PRV_M:   priv_ok = priv_en_i[2];
      PRV_VU:  priv_ok = priv_en_i[3];
      PRV_VS:  priv_ok = priv_en_i[4];
      default: priv_ok = 1'b0;
    endcase

    size_ok = (nbytes != 5'd0)
           && ((size_i == 3'd0) || (size_i == acc_size_i))
           && !((size_i == SZ_48) && (acc_kind_i != KIND_EXEC));
    unc_ok  = !acc_uncertain_i || uncert_en_i;

    match_o = mode_ok && size_ok && kind_ok && priv_ok && unc_ok && cmp_hit;
  end

endmodule

// File: rtl/trig_chain.sv
module trig_chain #(
  parameter int NTRIG = 4
) (
  input  logic [NTRIG-1:0] match_i,
  input  logic [NTRIG-1:0] chain_i,
  output logic [NTRIG-1:0] fire_o,
  output logic [NTRIG-1:0] permit_o
);

  logic [NTRIG-1:0] ok;

  always_comb begin
    logic prev_chain, prev_ok, cur, next_fire;
    prev_chain = 1'b0;
    prev_ok    = 1'b0;
    // upward pass: a member is live if it matched and its predecessor allowed it
    for (int i = 0; i < NTRIG; i++) begin
      cur         = match_i[i] && (!prev_chain || prev_ok);
      ok[i]       = cur;
      permit_o[i] = !chain_i[i] || cur;
      prev_chain  = chain_i[i];
      prev_ok     = cur;
    end
    // downward pass: the tail decides, members inherit
    next_fire = 1'b0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      cur       = chain_i[i] ? (match_i[i] && next_fire) : ok[i];
      fire_o[i] = cur;
      next_fire = cur;
    end
  end

endmodule

// File: rtl/trig_bank.sv
module trig_bank #(
  parameter int XLEN      = 32,
  parameter int NTRIG     = 4,
  parameter int NAPOT_MAX = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       acc_valid_i,
  input  logic [1:0]                 acc_kind_i,
  input  logic [XLEN-1:0]            acc_addr_i,
  input  logic [XLEN-1:0]            acc_data_i,
  input  logic [2:0]                 acc_size_i,
  input  logic [2:0]                 acc_priv_i,
  input  logic                       acc_uncertain_i,
  input  logic [NTRIG-1:0][3:0]      cfg_mode_i,
  input  logic [NTRIG-1:0]           cfg_select_i,
  input  logic [NTRIG-1:0]           cfg_timing_i,
  input  logic [NTRIG-1:0][2:0]      cfg_size_i,
  input  logic [NTRIG-1:0]           cfg_chain_i,
  input  logic [NTRIG-1:0][2:0]      cfg_kind_en_i,
  input  logic [NTRIG-1:0][4:0]      cfg_priv_en_i,
  input  logic [NTRIG-1:0]           cfg_uncert_en_i,
  input  logic [NTRIG-1:0][XLEN-1:0] cfg_value_i,
  input  logic [NTRIG-1:0]           hit_clr_i,
  output logic [NTRIG-1:0]           match_o,
  output logic [NTRIG-1:0]           permit_o,
  output logic [NTRIG-1:0]           fire_o,
  output logic [NTRIG-1:0][1:0]      hit_o,
  output logic [NTRIG-1:0]           uncert_o
);

  localparam int LANES = 16;
  localparam logic [1:0] HIT_BEFORE = 2'd1;
  localparam logic [1:0] HIT_AFTER  = 2'd3;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [NTRIG-1:0]      unit_match, chain_fire, chain_permit;
  logic [NTRIG-1:0]      match_d, permit_d, fire_d, unc_d, state_en;
  logic [NTRIG-1:0][1:0] hit_d;

  for (genvar t = 0; t < NTRIG; t++) begin : g_trig
    trig_unit #(.XLEN(XLEN), .NAPOT_MAX(NAPOT_MAX), .LANES(LANES)) unit_i (
      .acc_kind_i      (acc_kind_i),
      .acc_addr_i      (acc_addr_i),
      .acc_data_i      (acc_data_i),
      .acc_size_i      (acc_size_i),
      .acc_priv_i      (acc_priv_i),
      .acc_uncertain_i (acc_uncertain_i),
      .mode_i          (cfg_mode_i[t]),
      .select_i        (cfg_select_i[t]),
      .size_i          (cfg_size_i[t]),
      .kind_en_i       (cfg_kind_en_i[t]),
      .priv_en_i       (cfg_priv_en_i[t]),
      .uncert_en_i     (cfg_uncert_en_i[t]),
      .value_i         (cfg_value_i[t]),
      .match_o         (unit_match[t])
    );
  end

  trig_chain #(.NTRIG(NTRIG)) chain_i (
    .match_i  (unit_match),
    .chain_i  (cfg_chain_i),
    .fire_o   (chain_fire),
    .permit_o (chain_permit)
  );

  // next-state
  always_comb begin
    match_d  = acc_valid_i ? unit_match   : '0;
    permit_d = acc_valid_i ? chain_permit : '0;
    fire_d   = acc_valid_i ? chain_fire   : '0;
    for (int t = 0; t < NTRIG; t++) begin
      state_en[t] = fire_d[t] || hit_clr_i[t];
      if (fire_d[t]) begin
        hit_d[t] = cfg_timing_i[t] ? HIT_AFTER : HIT_BEFORE;
        unc_d[t] = acc_uncertain_i || (uncert_o[t] && !hit_clr_i[t]);
      end else begin
        hit_d[t] = 2'd0;
        unc_d[t] = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      match_o  <= '0;
      permit_o <= '0;
      fire_o   <= '0;
    end else begin
      match_o  <= match_d;
      permit_o <= permit_d;
      fire_o   <= fire_d;
    end
  end

  for (genvar t = 0; t < NTRIG; t++) begin : g_state
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        hit_o[t]    <= 2'd0;
        uncert_o[t] <= 1'b0;
      end else if (state_en[t]) begin
        hit_o[t]    <= hit_d[t];
        uncert_o[t] <= unc_d[t];
      end
    end

    assert_fire_has_match_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
      fire_o[t] |-> match_o[t]);
    assert_permit_unchained_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
      (acc_valid_i && !cfg_chain_i[t]) |=> permit_o[t]);
    assert_quiet_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
      !acc_valid_i |=> (!fire_o[t] && !match_o[t] && !permit_o[t]));
    assert_hit_on_fire_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
      fire_o[t] |-> (hit_o[t] != 2'd0));
    assert_hit_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
      ((hit_o[t] != 2'd0) && !hit_clr_i[t]) |=> (hit_o[t] != 2'd0));
    assert_uncert_needs_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
      $rose(uncert_o[t]) |-> fire_o[t]);
  end

endmodule

// File: tb/trig_bank_tb.sv
module trig_bank_tb_top;

  localparam int XLEN = 32;
  localparam int NT   = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic                  acc_valid, acc_unc;
  logic [1:0]            acc_kind;
  logic [XLEN-1:0]       acc_addr, acc_data;
  logic [2:0]            acc_size, acc_priv;
  logic [NT-1:0][3:0]    cfg_mode;
  logic [NT-1:0]         cfg_sel, cfg_tim, cfg_chain, cfg_uen, hit_clr;
  logic [NT-1:0][2:0]    cfg_size, cfg_ken;
  logic [NT-1:0][4:0]    cfg_pen;
  logic [NT-1:0][XLEN-1:0] cfg_val;
  logic [NT-1:0]         match_o, permit_o, fire_o, uncert_o;
  logic [NT-1:0][1:0]    hit_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  trig_bank #(.XLEN(XLEN), .NTRIG(NT), .NAPOT_MAX(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_kind_i(acc_kind),
    .acc_addr_i(acc_addr), .acc_data_i(acc_data), .acc_size_i(acc_size),
    .acc_priv_i(acc_priv), .acc_uncertain_i(acc_unc), .cfg_mode_i(cfg_mode),
    .cfg_select_i(cfg_sel), .cfg_timing_i(cfg_tim), .cfg_size_i(cfg_size),
    .cfg_chain_i(cfg_chain), .cfg_kind_en_i(cfg_ken), .cfg_priv_en_i(cfg_pen),
    .cfg_uncert_en_i(cfg_uen), .cfg_value_i(cfg_val), .hit_clr_i(hit_clr),
    .match_o(match_o), .permit_o(permit_o), .fire_o(fire_o), .hit_o(hit_o),
    .uncert_o(uncert_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    cfg_mode = '0; cfg_sel = '0; cfg_tim = '0; cfg_chain = '0; cfg_uen = '0;
    cfg_size = '0; cfg_ken = '0; cfg_pen = '0; cfg_val = '0;
  endtask

  task automatic set_t(input int i, input logic [3:0] mode, input logic sel,
                       input logic [2:0] sz, input logic ch, input logic [2:0] ken,
                       input logic [4:0] pen, input logic [31:0] val);
    cfg_mode[i] = mode; cfg_sel[i] = sel; cfg_size[i] = sz; cfg_chain[i] = ch;
    cfg_ken[i] = ken; cfg_pen[i] = pen; cfg_val[i] = val;
    cfg_tim[i] = 1'b0; cfg_uen[i] = 1'b0;
  endtask

  // called at a falling edge; returns at the next falling edge with results visible
  task automatic do_acc(input logic [1:0] kind, input logic [31:0] addr,
                        input logic [31:0] data, input logic [2:0] sz,
                        input logic [2:0] prv, input logic unc);
    acc_valid = 1'b1; acc_kind = kind; acc_addr = addr; acc_data = data;
    acc_size = sz; acc_priv = prv; acc_unc = unc;
    @(negedge clk);
    acc_valid = 1'b0; acc_unc = 1'b0;
  endtask

  task automatic clr_hits();
    hit_clr = '1;
    @(negedge clk);
    hit_clr = '0;
  endtask

  task automatic t_reset();
    chk("R12 reset match", 32'(match_o), 0);
    chk("R12 reset fire", 32'(fire_o), 0);
    chk("R12 reset hit", 32'(hit_o), 0);
  endtask

  task automatic t_equal();
    clear_cfg(); set_t(0, 4'd0, 0, 3'd0, 0, 3'b111, 5'b11111, 32'h1000);
    do_acc(0, 32'h1000, 0, 3'd3, 3'd3, 0); chk("R1 equal base", 32'(fire_o[0]), 1);
    do_acc(0, 32'h0FFE, 0, 3'd3, 3'd3, 0); chk("R5 upper byte lane", 32'(match_o[0]), 1);
    do_acc(0, 32'h0FFC, 0, 3'd3, 3'd3, 0); chk("R5 word below", 32'(match_o[0]), 0);
    cfg_mode[0] = 4'd8;
    do_acc(0, 32'h0FFC, 0, 3'd3, 3'd3, 0); chk("R1 not-equal miss", 32'(match_o[0]), 1);
    do_acc(0, 32'h0FFE, 0, 3'd3, 3'd3, 0); chk("R5 inverse whole access", 32'(match_o[0]), 0);
  endtask

  task automatic t_napot();
    clear_cfg(); set_t(0, 4'd1, 0, 3'd0, 0, 3'b111, 5'b11111, 32'h10FF);
    do_acc(1, 32'h11FC, 0, 3'd1, 3'd3, 0); chk("R2 region top", 32'(match_o[0]), 1);
    do_acc(1, 32'h1200, 0, 3'd1, 3'd3, 0); chk("R2 above region", 32'(match_o[0]), 0);
    do_acc(1, 32'h0FFF, 0, 3'd1, 3'd3, 0); chk("R2 below region", 32'(match_o[0]), 0);
    cfg_val[0] = 32'h7FFF;
    do_acc(1, 32'h7004, 0, 3'd1, 3'd3, 0); chk("R2 capped inside", 32'(match_o[0]), 1);
    do_acc(1, 32'h0004, 0, 3'd1, 3'd3, 0); chk("R2 cap enforced", 32'(match_o[0]), 0);
    cfg_mode[0] = 4'd9; cfg_val[0] = 32'h10FF;
    do_acc(1, 32'h1200, 0, 3'd1, 3'd3, 0); chk("R2 inverse region", 32'(match_o[0]), 1);
  endtask

  task automatic t_range();
    clear_cfg(); set_t(0, 4'd2, 0, 3'd0, 0, 3'b111, 5'b11111, 32'h2000);
    do_acc(2, 32'h1FFC, 0, 3'd3, 3'd3, 0); chk("R3 ge below", 32'(match_o[0]), 0);
    do_acc(2, 32'h1FFC, 0, 3'd5, 3'd3, 0); chk("R3 ge reached by lane", 32'(match_o[0]), 1);
    cfg_mode[0] = 4'd3;
    do_acc(2, 32'h2000, 0, 3'd1, 3'd3, 0); chk("R3 lt equal", 32'(match_o[0]), 0);
    do_acc(2, 32'h1FFF, 0, 3'd1, 3'd3, 0); chk("R3 lt below", 32'(match_o[0]), 1);
    do_acc(2, 32'h8000_0000, 0, 3'd1, 3'd3, 0); chk("R3 lt unsigned", 32'(match_o[0]), 0);
  endtask

  task automatic t_mask();
    clear_cfg(); set_t(0, 4'd4, 0, 3'd0, 0, 3'b111, 5'b11111, 32'h00F0_0030);
    do_acc(1, 32'h0000_1234, 0, 3'd1, 3'd3, 0); chk("R4 mask low hit", 32'(match_o[0]), 1);
    do_acc(1, 32'h0000_1244, 0, 3'd1, 3'd3, 0); chk("R4 mask low miss", 32'(match_o[0]), 0);
    cfg_mode[0] = 4'd12;
    do_acc(1, 32'h0000_1244, 0, 3'd1, 3'd3, 0); chk("R4 inverse low", 32'(match_o[0]), 1);
    cfg_mode[0] = 4'd5; cfg_val[0] = 32'hFF00_1200;
    do_acc(1, 32'h12AB_0000, 0, 3'd1, 3'd3, 0); chk("R4 mask high hit", 32'(match_o[0]), 1);
    do_acc(1, 32'h13AB_0000, 0, 3'd1, 3'd3, 0); chk("R4 mask high miss", 32'(match_o[0]), 0);
    cfg_mode[0] = 4'd13;
    do_acc(1, 32'h13AB_0000, 0, 3'd1, 3'd3, 0); chk("R4 inverse high", 32'(match_o[0]), 1);
  endtask

  task automatic t_data();
    clear_cfg(); set_t(0, 4'd0, 1, 3'd0, 0, 3'b111, 5'b11111, 32'h0000_00AB);
    do_acc(1, 32'h9000, 32'hFFFF_FFAB, 3'd1, 3'd3, 0); chk("R6 byte zero-extended", 32'(match_o[0]), 1);
    do_acc(1, 32'h9000, 32'hFFFF_FFAB, 3'd3, 3'd3, 0); chk("R6 word full", 32'(match_o[0]), 0);
    cfg_val[0] = 32'hFFFF_FFAB;
    do_acc(2, 32'h9000, 32'hFFFF_FFAB, 3'd3, 3'd3, 0); chk("R6 word equal", 32'(match_o[0]), 1);
  endtask

  task automatic t_size();
    clear_cfg(); set_t(0, 4'd0, 0, 3'd2, 0, 3'b111, 5'b11111, 32'h3000);
    do_acc(1, 32'h3000, 0, 3'd2, 3'd3, 0); chk("R7 size equal", 32'(match_o[0]), 1);
    do_acc(1, 32'h3000, 0, 3'd1, 3'd3, 0); chk("R7 size differs", 32'(match_o[0]), 0);
    cfg_size[0] = 3'd4;
    do_acc(0, 32'h3000, 0, 3'd4, 3'd3, 0); chk("R7 48-bit execute", 32'(match_o[0]), 1);
    do_acc(1, 32'h3000, 0, 3'd4, 3'd3, 0); chk("R7 48-bit load refused", 32'(match_o[0]), 0);
  endtask

  task automatic t_kind_priv();
    clear_cfg(); set_t(0, 4'd0, 0, 3'd0, 0, 3'b010, 5'b10100, 32'h4000);
    do_acc(1, 32'h4000, 0, 3'd1, 3'd3, 0); chk("R8 load in M", 32'(match_o[0]), 1);
    do_acc(2, 32'h4000, 0, 3'd1, 3'd3, 0); chk("R8 store disabled", 32'(match_o[0]), 0);
    do_acc(1, 32'h4000, 0, 3'd1, 3'd0, 0); chk("R8 U disabled", 32'(match_o[0]), 0);
    do_acc(1, 32'h4000, 0, 3'd1, 3'd5, 0); chk("R8 VS enabled", 32'(match_o[0]), 1);
    cfg_ken[0] = 3'b111; cfg_pen[0] = 5'b11111;
    do_acc(1, 32'h4000, 0, 3'd1, 3'd2, 0); chk("R8 reserved priv", 32'(match_o[0]), 0);
  endtask

  task automatic t_uncertain();
    clear_cfg(); clr_hits(); set_t(0, 4'd0, 0, 3'd0, 0, 3'b111, 5'b11111, 32'h5000);
    do_acc(1, 32'h5000, 0, 3'd1, 3'd3, 1); chk("R9 uncertain blocked", 32'(fire_o[0]), 0);
    chk("R9 flag clear", 32'(uncert_o[0]), 0);
    cfg_uen[0] = 1'b1;
    do_acc(1, 32'h5000, 0, 3'd1, 3'd3, 1); chk("R9 uncertain fires", 32'(fire_o[0]), 1);
    chk("R9 flag set", 32'(uncert_o[0]), 1);
    do_acc(1, 32'h5000, 0, 3'd1, 3'd3, 0); chk("R9 flag sticky", 32'(uncert_o[0]), 1);
    clr_hits(); chk("R9 flag cleared", 32'(uncert_o[0]), 0);
  endtask

  task automatic t_chain();
    clear_cfg(); clr_hits();
    set_t(0, 4'd0, 0, 3'd0, 1, 3'b111, 5'b11111, 32'h5000);
    set_t(1, 4'd0, 1, 3'd0, 0, 3'b111, 5'b11111, 32'h77);
    do_acc(1, 32'h5000, 32'h77, 3'd1, 3'd3, 0);
    chk("R10 chain fires both", 32'(fire_o[1:0]), 32'h3);
    chk("R11 hit both members", 32'({hit_o[1], hit_o[0]}), 32'h5);
    do_acc(1, 32'h5004, 32'h77, 3'd1, 3'd3, 0);
    chk("R10 head miss blocks", 32'(fire_o[1:0]), 0);
    chk("R10 tail still matches", 32'(match_o[1]), 1);
    chk("R10 head permit low", 32'(permit_o[0]), 0);
    do_acc(1, 32'h5000, 32'h78, 3'd1, 3'd3, 0);
    chk("R10 tail miss", 32'(fire_o[1:0]), 0);
    chk("R10 head permit high", 32'(permit_o[0]), 1);
    chk("R10 unchained permit", 32'(permit_o[1]), 1);
    set_t(3, 4'd0, 0, 3'd0, 1, 3'b111, 5'b11111, 32'h5000);
    do_acc(1, 32'h5000, 32'h0, 3'd1, 3'd3, 0);
    chk("R10 open chain never fires", 32'(fire_o[3]), 0);
    chk("R10 open chain matched", 32'(match_o[3]), 1);
  endtask

  task automatic t_hit();
    clear_cfg(); clr_hits();
    set_t(0, 4'd0, 0, 3'd0, 0, 3'b111, 5'b11111, 32'h1000);
    cfg_tim[0] = 1'b1;
    do_acc(0, 32'h1000, 0, 3'd3, 3'd3, 0); chk("R11 after code", 32'(hit_o[0]), 3);
    @(negedge clk); chk("R11 sticky idle", 32'(hit_o[0]), 3);
    chk("R12 idle fire low", 32'(fire_o), 0);
    chk("R12 idle match low", 32'(match_o), 0);
    clr_hits(); chk("R11 cleared", 32'(hit_o[0]), 0);
    cfg_tim[0] = 1'b0;
    do_acc(0, 32'h1000, 0, 3'd3, 3'd3, 0); chk("R11 before code", 32'(hit_o[0]), 1);
    cfg_tim[0] = 1'b1; hit_clr[0] = 1'b1;
    do_acc(0, 32'h1000, 0, 3'd3, 3'd3, 0); hit_clr = '0;
    chk("R11 fire beats clear", 32'(hit_o[0]), 3);
  endtask

  task automatic t_reserved();
    clear_cfg(); set_t(0, 4'd6, 0, 3'd0, 0, 3'b111, 5'b11111, 32'h1000);
    do_acc(0, 32'h1000, 0, 3'd1, 3'd3, 0); chk("R13 mode 6", 32'(match_o[0]), 0);
    cfg_mode[0] = 4'd10;
    do_acc(0, 32'h1000, 0, 3'd1, 3'd3, 0); chk("R13 mode 10", 32'(match_o[0]), 0);
    cfg_mode[0] = 4'd15;
    do_acc(0, 32'h0FFF, 0, 3'd1, 3'd3, 0); chk("R13 mode 15", 32'(match_o[0]), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_kind = '0; acc_addr = '0; acc_data = '0;
    acc_size = '0; acc_priv = '0; acc_unc = 1'b0; hit_clr = '0;
    clear_cfg();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_equal();
    t_napot();
    t_range();
    t_mask();
    t_data();
    t_size();
    t_kind_priv();
    t_uncertain();
    t_chain();
    t_hit();
    t_reserved();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule